// File: doc/BRIEF.md
# Floating-Point Transfer Issue Interlock

This block sits in the issue stage of a pipeline that has an integer register file and a floating-point register file. Each cycle it looks at one decoded transfer instruction and decides whether it may issue. It holds the instruction when any of three conditions applies:

- a system-register write is still occupying its blocking window;
- a serializing access meets floating-point operations that complete out of order and have not yet finished;
- a source register is still waiting on a slower transfer result.

The unit that issues the out-of-order operations reports each one with an issue pulse and each completion with a done pulse. The block counts them. When an instruction issues, the block reports its result latency so that later consumers can be interlocked. Data movement and arithmetic take place elsewhere.

Top module: `fxi_xfer_interlock`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it is released, `stall_o` and `busy_o` are 0. Reset empties the outstanding-operation count, the blocking timer and the scoreboard, so a serializing read issues at once after reset.
- R2: `class_i` is encoded as follows: 0 other, 1 integer-to-FP-data, 2 FP-data-to-integer, 3 system-register write, 4 system-register read, 5 status-flag move. In a cycle where `issue_o` is high, `res_lat_o` is 1 for class 1, 2 for classes 2 and 4, and 0 for all other classes. In every other cycle `res_lat_o` is 0.
- R3: `issue_o` equals `valid_i && !stall_o`. When `valid_i` is 0, `stall_o` is 0.
- R4: Suppose a system-register write issues in cycle t. Then `busy_o` is high in cycles t+1 to t+5, and every valid instruction in those cycles stalls. In cycle t+6 `busy_o` is low, which gives 6 cycles of occupancy in total.
- R5: Classes 3, 4 and 5 stall while the outstanding out-of-order count is nonzero. Classes 0, 1 and 2 are not held by that count.
- R6: The count goes up on `ooo_issue_i` and down on `ooo_done_i`. When both pulses come in the same cycle, the count does not change. A done pulse when the count is zero leaves it at zero. A change to the count affects stalls from the next cycle onward.
- R7: Suppose a class 2 or class 4 instruction with integer destination `dst_i` issues in cycle t. Then in cycle t+1, an instruction that reads that tag through a valid source port stalls. In cycle t+2 it may issue.
- R8: A source port whose valid bit is 0 never causes a stall. A class 1 destination is a floating-point register, so it is never recorded as an integer hazard.
- R9: An instruction that stalls has no side effects: a stalled class 3 does not start the blocking window, and a stalled class 2 or class 4 does not record a hazard.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | A decoded transfer is presented |
| class_i | input | 3 | Transfer class (see R2) |
| dst_i | input | TAG_W | Integer destination tag |
| src_a_i | input | TAG_W | First integer source tag |
| src_a_vld_i | input | 1 | First source is read |
| src_b_i | input | TAG_W | Second integer source tag |
| src_b_vld_i | input | 1 | Second source is read |
| ooo_issue_i | input | 1 | An out-of-order FP operation started |
| ooo_done_i | input | 1 | An out-of-order FP operation completed |
| stall_o | output | 1 | Presented instruction is held |
| issue_o | output | 1 | Presented instruction issues this cycle |
| busy_o | output | 1 | Blocking window of a system-register write is active |
| res_lat_o | output | LAT_W | Result latency of the issuing instruction |

## Verification
The assertions check on every cycle the following rules:

- the blocking window starts after each system-register write and never runs longer than its fixed length;
- a serializing class is held whenever the count is nonzero;
- simultaneous issue and done pulses leave the count unchanged;
- a read-after-write in the cycle after a slow transfer is stalled;
- FP-data-to-integer transfers report a latency of 2.

Other behaviours appear only in the bench's scenarios. These are:

- the exact cycle in which the window releases;
- whether a stalled write leaves no trace;
- the count staying at zero on a lone done pulse;
- invalid source ports being ignored;
- a reset in the middle of a window clearing everything.

// File: rtl/fxi_pkg.sv
package fxi_pkg;
  typedef enum logic [2:0] {
    XC_OTHER   = 3'd0,
    XC_TO_FP   = 3'd1,
    XC_FROM_FP = 3'd2,
    XC_SYS_WR  = 3'd3,
    XC_SYS_RD  = 3'd4,
    XC_FLAGS   = 3'd5
  } xfer_cls_e;

  function automatic logic cls_serial(logic [2:0] c);
    return (c == XC_SYS_WR) || (c == XC_SYS_RD) || (c == XC_FLAGS);
  endfunction

  function automatic logic cls_wr_int(logic [2:0] c);
    return (c == XC_FROM_FP) || (c == XC_SYS_RD);
  endfunction
endpackage

// File: rtl/fxi_ooo_cnt.sv
module fxi_ooo_cnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_o
);
  localparam logic [CNT_W-1:0] CntMax = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (inc_i && !dec_i && cnt_q != CntMax) begin
      cnt_q <= cnt_q + 1'b1;
    end else if (dec_i && !inc_i && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/fxi_blk_timer.sv
module fxi_blk_timer #(
  parameter int BLK_CYCLES = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int T_W = (BLK_CYCLES > 2) ? $clog2(BLK_CYCLES) : 1;
  localparam logic [T_W-1:0] Load = T_W'(BLK_CYCLES - 1);

  logic [T_W-1:0] tmr_q;

  // issue cycle counts as the first one, so load one less
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q <= '0;
    end else if (start_i) begin
      tmr_q <= Load;
    end else if (tmr_q != '0) begin
      tmr_q <= tmr_q - 1'b1;
    end
  end

  assign busy_o = (tmr_q != '0);
endmodule

// File: rtl/fxi_scoreboard.sv
module fxi_scoreboard #(
  parameter int TAG_W = 4,
  parameter int LAT   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic [TAG_W-1:0] set_tag_i,
  input  logic [TAG_W-1:0] rd_a_i,
  input  logic             rd_a_vld_i,
  input  logic [TAG_W-1:0] rd_b_i,
  input  logic             rd_b_vld_i,
  output logic             hazard_o
);
  localparam int NREG = 1 << TAG_W;
  localparam int LOAD = LAT - 1;
  localparam int W    = (LOAD > 1) ? $clog2(LOAD + 1) : 1;

  logic [NREG-1:0] pend;

  for (genvar g = 0; g < NREG; g++) begin : g_ent
    logic [W-1:0] wait_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        wait_q <= '0;
      end else if (set_i && set_tag_i == TAG_W'(g)) begin
        wait_q <= W'(LOAD);
      end else if (wait_q != '0) begin
        wait_q <= wait_q - 1'b1;
      end
    end
    assign pend[g] = (wait_q != '0);
  end

  assign hazard_o = (rd_a_vld_i && pend[rd_a_i]) || (rd_b_vld_i && pend[rd_b_i]);
endmodule

// File: rtl/fxi_xfer_interlock.sv
module fxi_xfer_interlock
  import fxi_pkg::*;
#(
  parameter int TAG_W       = 4,
  parameter int CNT_W       = 4,
  parameter int BLK_CYCLES  = 6,
  parameter int LAT_TO_FP   = 1,
  parameter int LAT_FROM_FP = 2,
  parameter int LAT_W       = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [2:0]       class_i,
  input  logic [TAG_W-1:0] dst_i,
  input  logic [TAG_W-1:0] src_a_i,
  input  logic             src_a_vld_i,
  input  logic [TAG_W-1:0] src_b_i,
  input  logic             src_b_vld_i,
  input  logic             ooo_issue_i,
  input  logic             ooo_done_i,
  output logic             stall_o,
  output logic             issue_o,
  output logic             busy_o,
  output logic [LAT_W-1:0] res_lat_o
);
  logic [CNT_W-1:0] ooo_cnt;
  logic             ooo_zero;
  logic             blk_busy;
  logic             raw_haz;
  logic             ser_hold;

  fxi_ooo_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (ooo_issue_i),
    .dec_i  (ooo_done_i),
    .cnt_o  (ooo_cnt),
    .zero_o (ooo_zero)
  );

  fxi_blk_timer #(.BLK_CYCLES(BLK_CYCLES)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (issue_o && class_i == XC_SYS_WR),
    .busy_o  (blk_busy)
  );

  fxi_scoreboard #(.TAG_W(TAG_W), .LAT(LAT_FROM_FP)) u_sb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (issue_o && cls_wr_int(class_i)),
    .set_tag_i  (dst_i),
    .rd_a_i     (src_a_i),
    .rd_a_vld_i (src_a_vld_i),
    .rd_b_i     (src_b_i),
    .rd_b_vld_i (src_b_vld_i),
    .hazard_o   (raw_haz)
  );

  assign ser_hold = cls_serial(class_i) && !ooo_zero;
  assign stall_o  = valid_i && (blk_busy || ser_hold || raw_haz);
  assign issue_o  = valid_i && !stall_o;
  assign busy_o   = blk_busy;

  always_comb begin
    res_lat_o = '0;
    if (issue_o) begin
      unique case (class_i)
        XC_TO_FP:            res_lat_o = LAT_W'(LAT_TO_FP);
        XC_FROM_FP, XC_SYS_RD: res_lat_o = LAT_W'(LAT_FROM_FP);
        default:             res_lat_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/fxi_xfer_interlock_chk.sv
module fxi_xfer_interlock_chk
  import fxi_pkg::*;
#(
  parameter int TAG_W      = 4,
  parameter int CNT_W      = 4,
  parameter int BLK_CYCLES = 6,
  parameter int LAT_W      = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [2:0]       class_i,
  input logic [TAG_W-1:0] dst_i,
  input logic [TAG_W-1:0] src_a_i,
  input logic             src_a_vld_i,
  input logic             ooo_issue_i,
  input logic             ooo_done_i,
  input logic             stall_o,
  input logic             issue_o,
  input logic             busy_o,
  input logic [LAT_W-1:0] res_lat_o,
  input logic [CNT_W-1:0] ooo_cnt,
  input logic             ooo_zero
);
  logic [7:0] busy_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_run_q <= '0;
    else if (busy_o) busy_run_q <= busy_run_q + 1'b1;
    else             busy_run_q <= '0;
  end

  p_idle_no_stall_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> !stall_o);

  p_lat_from_fp_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_o && class_i == XC_FROM_FP) |-> res_lat_o == LAT_W'(2));

  p_busy_start_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_o && class_i == XC_SYS_WR) |=> busy_o);

  p_busy_len_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> busy_run_q < 8'(BLK_CYCLES - 1));

  p_busy_blocks_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && valid_i) |-> stall_o);

  p_serial_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cls_serial(class_i) && !ooo_zero) |-> stall_o);

  p_cnt_same_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ooo_issue_i && ooo_done_i) |=> $stable(ooo_cnt));

  p_raw_stall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_o && cls_wr_int(class_i)) |=>
      (!(valid_i && src_a_vld_i && src_a_i == $past(dst_i)) || stall_o));
endmodule

bind fxi_xfer_interlock fxi_xfer_interlock_chk #(
  .TAG_W(TAG_W), .CNT_W(CNT_W), .BLK_CYCLES(BLK_CYCLES), .LAT_W(LAT_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .class_i     (class_i),
  .dst_i       (dst_i),
  .src_a_i     (src_a_i),
  .src_a_vld_i (src_a_vld_i),
  .ooo_issue_i (ooo_issue_i),
  .ooo_done_i  (ooo_done_i),
  .stall_o     (stall_o),
  .issue_o     (issue_o),
  .busy_o      (busy_o),
  .res_lat_o   (res_lat_o),
  .ooo_cnt     (ooo_cnt),
  .ooo_zero    (ooo_zero)
);

// File: tb/fxi_xfer_interlock_tb.sv
module fxi_xfer_interlock_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0;
  logic [2:0] class_i = '0;
  logic [3:0] dst_i = '0, src_a_i = '0, src_b_i = '0;
  logic       src_a_vld_i = 1'b0, src_b_vld_i = 1'b0;
  logic       ooo_issue_i = 1'b0, ooo_done_i = 1'b0;
  logic       stall_o, issue_o, busy_o;
  logic [1:0] res_lat_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  fxi_xfer_interlock u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .class_i(class_i),
    .dst_i(dst_i), .src_a_i(src_a_i), .src_a_vld_i(src_a_vld_i),
    .src_b_i(src_b_i), .src_b_vld_i(src_b_vld_i),
    .ooo_issue_i(ooo_issue_i), .ooo_done_i(ooo_done_i),
    .stall_o(stall_o), .issue_o(issue_o), .busy_o(busy_o), .res_lat_o(res_lat_o)
  );

  typedef struct packed {
    logic       v;
    logic [2:0] cls;
    logic [3:0] dst;
    logic [3:0] sa;
    logic       sav;
    logic [3:0] sb;
    logic       sbv;
    logic       oi;
    logic       od;
    logic       es;
    logic       eb;
    logic [1:0] el;
    logic [7:0] rq;
  } vec_t;

  localparam int NV = 29;
  // v cls dst sa sav sb sbv oi od | stall busy lat | req
  localparam vec_t TBL [NV] = '{
    '{0,0,0,0,0,0,0,0,0, 0,0,0, 1},  // R1 idle after reset
    '{1,4,3,0,0,0,0,0,0, 0,0,2, 2},  // R2 sys read, count zero
    '{1,0,0,3,1,0,0,0,0, 1,0,0, 7},  // R7 read of tag 3 one cycle on
    '{1,0,0,0,0,3,1,0,0, 0,0,0, 7},  // R7 port b, two cycles on
    '{1,1,9,0,0,0,0,0,0, 0,0,1, 2},  // R2 int->fp
    '{1,2,5,9,1,0,0,0,0, 0,0,2, 8},  // R8 fp dest 9 not tracked
    '{1,0,0,5,0,5,0,0,0, 0,0,0, 8},  // R8 invalid sources
    '{0,0,0,0,0,0,0,1,0, 0,0,0, 6},  // R6 count -> 1
    '{1,4,2,0,0,0,0,1,1, 1,0,0, 5},  // R5 hold; R6 both pulses
    '{1,4,2,0,0,0,0,0,0, 1,0,0, 6},  // R6 still 1
    '{1,1,1,0,0,0,0,0,1, 0,0,1, 5},  // R5 class 1 not held
    '{1,5,0,0,0,0,0,0,0, 0,0,0, 5},  // R5 flags move, count 0
    '{1,3,0,0,0,0,0,0,0, 0,0,0, 4},  // R4 sys write issues
    '{1,0,0,0,0,0,0,0,0, 1,1,0, 4},
    '{0,0,0,0,0,0,0,0,0, 0,1,0, 4},
    '{1,1,0,0,0,0,0,0,0, 1,1,0, 4},
    '{0,0,0,0,0,0,0,0,0, 0,1,0, 4},
    '{1,0,0,0,0,0,0,0,0, 1,1,0, 4},  // R4 t+5
    '{1,0,0,0,0,0,0,0,0, 0,0,0, 4},  // R4 t+6 released
    '{0,0,0,0,0,0,0,1,0, 0,0,0, 6},
    '{1,3,0,0,0,0,0,0,0, 1,0,0, 9},  // R9 stalled write
    '{1,3,0,0,0,0,0,0,1, 1,0,0, 9},
    '{0,0,0,0,0,0,0,0,0, 0,0,0, 9},  // R9 no window started
    '{1,5,0,0,0,0,0,0,0, 0,0,0, 5},
    '{0,0,0,0,0,0,0,0,1, 0,0,0, 6},  // R6 done at zero
    '{1,4,4,0,0,0,0,0,0, 0,0,2, 6},  // R6 no underflow
    '{1,2,7,0,0,0,0,0,0, 0,0,2, 2},
    '{1,0,0,0,0,7,1,0,0, 1,0,0, 7},
    '{1,0,0,0,0,7,1,0,0, 0,0,0, 7}
  };

  task automatic check(input string req, input int row, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s row %0d: actual %0d expected %0d", req, row, act, exp);
    end
  endtask

  task automatic drive_idle();
    valid_i = 0; class_i = '0; dst_i = '0; src_a_i = '0; src_b_i = '0;
    src_a_vld_i = 0; src_b_vld_i = 0; ooo_issue_i = 0; ooo_done_i = 0;
  endtask

  initial begin
    #4000000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    drive_idle();
    #5;
    check("R1", -1, int'(stall_o), 0);
    check("R1", -1, int'(busy_o), 0);
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      valid_i = TBL[i].v; class_i = TBL[i].cls; dst_i = TBL[i].dst;
      src_a_i = TBL[i].sa; src_a_vld_i = TBL[i].sav;
      src_b_i = TBL[i].sb; src_b_vld_i = TBL[i].sbv;
      ooo_issue_i = TBL[i].oi; ooo_done_i = TBL[i].od;
      #5;
      check($sformatf("R%0d", TBL[i].rq), i, int'(stall_o), int'(TBL[i].es));
      check($sformatf("R%0d", TBL[i].rq), i, int'(busy_o), int'(TBL[i].eb));
      check("R2", i, int'(res_lat_o), int'(TBL[i].el));
      check("R3", i, int'(issue_o), int'(TBL[i].v && !TBL[i].es));
    end

    // R1: reset in the middle of a window clears timer, count and scoreboard
    @(negedge clk);
    drive_idle(); valid_i = 1; class_i = 3'd3;
    @(negedge clk);
    drive_idle(); valid_i = 1; class_i = 3'd2; dst_i = 4'd6;
    #5;
    check("R4", -1, int'(busy_o), 1);
    @(negedge clk);
    drive_idle(); ooo_issue_i = 1;
    @(negedge clk);
    drive_idle();
    rst_ni = 1'b0;
    #5;
    check("R1", -1, int'(busy_o), 0);
    check("R1", -1, int'(stall_o), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    valid_i = 1; class_i = 3'd4; dst_i = 4'd1; src_a_i = 4'd6; src_a_vld_i = 1;
    #5;
    check("R1", -1, int'(stall_o), 0);
    check("R1", -1, int'(busy_o), 0);
    check("R2", -1, int'(res_lat_o), 2);
    @(negedge clk);
    drive_idle();

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule